// File: doc/BRIEF.md
# Load Data Formatter

This block sits between the read data port of a data memory and the register file write port. It receives the raw little-endian bytes returned for a load, an opcode that picks the formatting mode, a sign-or-zero select, and the current contents of the 64-bit destination register pair. From these it builds the value to write back. The supported modes are plain sized loads with extension, byte-to-halfword expansion, and shift-in align loads that merge new bytes into the top of the existing pair. A predicate condition can cancel any load, in which case the destination gets zero.

The result appears on a registered output stage one clock after the request. A wide flag tells the register file whether the result fills a pair (64 bits) or a single 32-bit register. An unknown opcode returns zero and pulses an error flag.

Top module: `ld_format_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid`, `out_err`, `out_wide` and `out_data` all become 0.
- R2: Opcode 0 takes byte `rd_data[7:0]` and opcode 1 takes halfword `rd_data[15:0]`. Each is extended to 32 bits, by sign when `in_signed` is 1 and by zero when it is 0. Bits 63:32 of `out_data` are 0.
- R3: Opcode 2 writes `rd_data[31:0]` unchanged, with bits 63:32 equal to 0. Opcode 3 writes all 64 bits of `rd_data`.
- R4: Opcode 4 places byte i of `rd_data` (i = 0,1) into halfword i of a 32-bit result. Each byte is extended to 16 bits by sign or by zero as `in_signed` selects. Bits 63:32 are 0.
- R5: Opcode 5 places byte i of `rd_data` (i = 0..3) into halfword i of the 64-bit result, with the same per-byte extension.
- R6: Opcode 6 yields `dst_pair` shifted right by 16, with `rd_data[15:0]` placed in bits 63:48.
- R7: Opcode 7 yields `dst_pair` shifted right by 8, with `rd_data[7:0]` placed in bits 63:56.
- R8: When `pred_en` is 1 and the predicate condition is false, a defined opcode produces `out_data` = 0 whatever `rd_data` and `dst_pair` hold.
- R9: The predicate condition is `pred_flag` when `pred_inv` is 0, and its inverse when `pred_inv` is 1. When `pred_en` is 0 the condition is ignored.
- R10: `out_valid` equals `in_valid` delayed by one clock. A cycle with `in_valid` low leaves `out_data` and `out_wide` unchanged and `out_err` at 0.
- R11: Opcodes 8 to 15 produce `out_data` = 0, `out_wide` = 0 and `out_err` = 1 for that one output cycle only.
- R12: `out_wide` is 1 for opcodes 3, 5, 6 and 7, and 0 for opcodes 0, 1, 2 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| in_op | input | 4 | Formatting mode select |
| in_signed | input | 1 | 1 = sign extension, 0 = zero extension |
| rd_data | input | 64 | Raw memory read data, byte 0 in bits 7:0 |
| dst_pair | input | 64 | Current destination pair value |
| pred_en | input | 1 | Load is predicated |
| pred_flag | input | 1 | Predicate least significant bit |
| pred_inv | input | 1 | Invert predicate sense |
| out_valid | output | 1 | Result valid |
| out_data | output | 64 | Writeback value |
| out_wide | output | 1 | Result occupies the full pair |
| out_err | output | 1 | Undefined opcode seen |

## Verification
The assertions assume that `in_valid` is low while reset is held. They also assume that the data, predicate and opcode inputs are known whenever `in_valid` is high, because every output property is sampled from those inputs one cycle earlier. The stimulus drives all inputs on the falling edge and holds `in_valid` low throughout reset. It walks all sixteen opcode codes with both predicate senses, so the error, cancel and align properties are each triggered.

// File: rtl/ldf_pkg.sv
package ldf_pkg;

    typedef enum logic [3:0] {
        OP_LDB  = 4'd0,
        OP_LDH  = 4'd1,
        OP_LDW  = 4'd2,
        OP_LDD  = 4'd3,
        OP_EXP2 = 4'd4,
        OP_EXP4 = 4'd5,
        OP_ALH  = 4'd6,
        OP_ALB  = 4'd7
    } ldf_op_e;

    typedef struct packed {
        logic        valid;
        logic        err;
        logic        wide;
        logic [63:0] data;
    } ldf_stage_t;

endpackage

// File: rtl/ldf_extend.sv
module ldf_extend #(
    parameter int IN_W  = 8,
    parameter int OUT_W = 32
) (
    input  logic [IN_W-1:0]  din,
    input  logic             sgn,
    output logic [OUT_W-1:0] dout
);
    localparam int PAD_W = OUT_W - IN_W;

    logic fill;
    assign fill = sgn & din[IN_W-1];
    assign dout = {{PAD_W{fill}}, din};
endmodule

// File: rtl/ldf_expand.sv
module ldf_expand #(
    parameter int LANES  = 2,
    parameter int BYTE_W = 8,
    parameter int OUT_W  = 64
) (
    input  logic [LANES*BYTE_W-1:0] din,
    input  logic                    sgn,
    output logic [OUT_W-1:0]        dout
);
    localparam int LANE_W = 2 * BYTE_W;
    localparam int USED_W = LANES * LANE_W;

    logic [USED_W-1:0] lanes;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        ldf_extend #(.IN_W(BYTE_W), .OUT_W(LANE_W)) u_ext (
            .din  (din[g*BYTE_W +: BYTE_W]),
            .sgn  (sgn),
            .dout (lanes[g*LANE_W +: LANE_W])
        );
    end

    if (USED_W < OUT_W) begin : g_pad
        assign dout = {{(OUT_W-USED_W){1'b0}}, lanes};
    end else begin : g_full
        assign dout = lanes[OUT_W-1:0];
    end
endmodule

// File: rtl/ldf_align.sv
module ldf_align #(
    parameter int W     = 64,
    parameter int CHUNK = 16
) (
    input  logic [CHUNK-1:0] fresh,
    input  logic [W-1:0]     dst,
    output logic [W-1:0]     dout
);
    localparam int CAT_W = W + CHUNK;

    logic [CAT_W-1:0] joined;
    assign joined = {fresh, dst};
    assign dout   = W'(joined >> CHUNK);
endmodule

// File: rtl/ld_format_unit.sv
module ld_format_unit
    import ldf_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        in_op,
    input  logic              in_signed,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] dst_pair,
    input  logic              pred_en,
    input  logic              pred_flag,
    input  logic              pred_inv,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_wide,
    output logic              out_err
);
    localparam int WORD_W = DATA_W / 2;
    localparam int HALF_W = 2 * BYTE_W;

    logic [WORD_W-1:0] ext_b, ext_h;
    logic [DATA_W-1:0] exp2_v, exp4_v, alh_v, alb_v;

    ldf_extend #(.IN_W(BYTE_W), .OUT_W(WORD_W)) u_ext_b (
        .din(rd_data[BYTE_W-1:0]), .sgn(in_signed), .dout(ext_b));
    ldf_extend #(.IN_W(HALF_W), .OUT_W(WORD_W)) u_ext_h (
        .din(rd_data[HALF_W-1:0]), .sgn(in_signed), .dout(ext_h));

    ldf_expand #(.LANES(2), .BYTE_W(BYTE_W), .OUT_W(DATA_W)) u_exp2 (
        .din(rd_data[2*BYTE_W-1:0]), .sgn(in_signed), .dout(exp2_v));
    ldf_expand #(.LANES(4), .BYTE_W(BYTE_W), .OUT_W(DATA_W)) u_exp4 (
        .din(rd_data[4*BYTE_W-1:0]), .sgn(in_signed), .dout(exp4_v));

    ldf_align #(.W(DATA_W), .CHUNK(HALF_W)) u_alh (
        .fresh(rd_data[HALF_W-1:0]), .dst(dst_pair), .dout(alh_v));
    ldf_align #(.W(DATA_W), .CHUNK(BYTE_W)) u_alb (
        .fresh(rd_data[BYTE_W-1:0]), .dst(dst_pair), .dout(alb_v));

    ldf_stage_t st_d, st_q;
    logic              pred_ok;
    logic              known;
    logic              wide;
    logic [DATA_W-1:0] fmt;

    always_comb begin
        pred_ok = ~pred_en | (pred_flag ^ pred_inv);
        known   = 1'b1;
        wide    = 1'b0;
        fmt     = '0;
        case (in_op)
            OP_LDB:  fmt = {{WORD_W{1'b0}}, ext_b};
            OP_LDH:  fmt = {{WORD_W{1'b0}}, ext_h};
            OP_LDW:  fmt = {{WORD_W{1'b0}}, rd_data[WORD_W-1:0]};
            OP_LDD:  begin fmt = rd_data; wide = 1'b1; end
            OP_EXP2: fmt = exp2_v;
            OP_EXP4: begin fmt = exp4_v; wide = 1'b1; end
            OP_ALH:  begin fmt = alh_v;  wide = 1'b1; end
            OP_ALB:  begin fmt = alb_v;  wide = 1'b1; end
            default: known = 1'b0;
        endcase

        st_d       = st_q;
        st_d.valid = in_valid;
        st_d.err   = 1'b0;
        if (in_valid) begin
            if (!known) begin
                st_d.data = '0;
                st_d.wide = 1'b0;
                st_d.err  = 1'b1;
            end else begin
                st_d.data = pred_ok ? fmt : '0;
                st_d.wide = wide;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_err   = st_q.err;
    assign out_wide  = st_q.wide;
    assign out_data  = st_q.data;
endmodule

// File: rtl/ld_format_checker.sv
module ld_format_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [3:0]  in_op,
    input logic        in_signed,
    input logic [63:0] rd_data,
    input logic [63:0] dst_pair,
    input logic        pred_en,
    input logic        pred_flag,
    input logic        pred_inv,
    input logic        out_valid,
    input logic [63:0] out_data,
    input logic        out_wide,
    input logic        out_err
);
    a_r10_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r10_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_err && $stable(out_data) && $stable(out_wide)));
    a_r11_bad_op: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op[3]) |=> (out_err && out_data == 64'd0 && !out_wide));
    a_r11_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_op[3]) |=> !out_err);
    a_r8_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pred_en && (pred_flag == pred_inv)) |=> out_data == 64'd0);
    a_r6_align_half: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 4'd6 && !pred_en) |=>
        (out_data[47:0] == $past(dst_pair[63:16]) && out_data[63:48] == $past(rd_data[15:0])));
    a_r7_align_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 4'd7 && !pred_en) |=>
        (out_data[55:0] == $past(dst_pair[63:8]) && out_data[63:56] == $past(rd_data[7:0])));
    a_r3_pass_word: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 4'd2 && !pred_en) |=> out_data == {32'd0, $past(rd_data[31:0])});
    a_r12_narrow_top: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op == 4'd0 || in_op == 4'd1 || in_op == 4'd2 || in_op == 4'd4))
        |=> (!out_wide && out_data[63:32] == 32'd0));
    a_r11_err_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> out_valid);
endmodule

bind ld_format_unit ld_format_checker u_ld_format_checker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_signed(in_signed), .rd_data(rd_data), .dst_pair(dst_pair),
    .pred_en(pred_en), .pred_flag(pred_flag), .pred_inv(pred_inv),
    .out_valid(out_valid), .out_data(out_data), .out_wide(out_wide),
    .out_err(out_err)
);

// File: tb/ld_format_unit_bench.sv
module ld_format_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_op = '0;
    logic        in_signed = 1'b0;
    logic [63:0] rd_data = '0;
    logic [63:0] dst_pair = '0;
    logic        pred_en = 1'b0;
    logic        pred_flag = 1'b0;
    logic        pred_inv = 1'b0;
    logic        out_valid;
    logic [63:0] out_data;
    logic        out_wide;
    logic        out_err;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    ld_format_unit u_ld_format_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_signed(in_signed), .rd_data(rd_data), .dst_pair(dst_pair),
        .pred_en(pred_en), .pred_flag(pred_flag), .pred_inv(pred_inv),
        .out_valid(out_valid), .out_data(out_data), .out_wide(out_wide),
        .out_err(out_err)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [3:0] op, input logic cancel);
        if (op > 4'd7) return "R11";
        if (cancel)    return "R8";
        case (op)
            4'd0, 4'd1: return "R2";
            4'd2, 4'd3: return "R3";
            4'd4:       return "R4";
            4'd5:       return "R5";
            4'd6:       return "R6";
            default:    return "R7";
        endcase
    endfunction

    // behavioural reference model
    task automatic model(input logic [3:0] op, input logic sg, input logic [63:0] rd,
                         input logic [63:0] dst, input logic pe, input logic pf,
                         input logic pi, output logic [63:0] d, output logic w,
                         output logic e);
        longint unsigned acc;
        logic go;
        acc = 0;
        w = 1'b0;
        e = 1'b0;
        go = !pe || (pi ? !pf : pf);
        case (op)
            4'd0: begin acc = rd & 64'hFF; if (sg && rd[7]) acc = acc | 64'hFFFF_FF00; end
            4'd1: begin acc = rd & 64'hFFFF; if (sg && rd[15]) acc = acc | 64'hFFFF_0000; end
            4'd2: acc = rd & 64'hFFFF_FFFF;
            4'd3: begin acc = rd; w = 1'b1; end
            4'd4, 4'd5: begin
                int nb;
                nb = (op == 4'd4) ? 2 : 4;
                w = (op == 4'd5);
                for (int i = 0; i < nb; i++) begin
                    longint unsigned b;
                    b = (rd >> (8 * i)) & 64'hFF;
                    if (sg && b[7]) b = b + 64'hFF00;
                    acc = acc + (b << (16 * i));
                end
            end
            4'd6: begin acc = (dst >> 16) + ((rd & 64'hFFFF) << 48); w = 1'b1; end
            4'd7: begin acc = (dst >> 8) + ((rd & 64'hFF) << 56); w = 1'b1; end
            default: begin e = 1'b1; go = 1'b0; end
        endcase
        d = go ? acc : 64'd0;
    endtask

    task automatic run(input logic [3:0] op, input logic sg, input logic [63:0] rd,
                       input logic [63:0] dst, input logic pe, input logic pf,
                       input logic pi, input logic [63:0] exp_d, input logic use_exp,
                       input string note);
        logic [63:0] md;
        logic mw, me;
        string tg;
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_signed = sg; rd_data = rd; dst_pair = dst;
        pred_en = pe; pred_flag = pf; pred_inv = pi;
        model(op, sg, rd, dst, pe, pf, pi, md, mw, me);
        tg = {tag_of(op, pe && (pf == pi)), " ", note};
        @(posedge clk);
        #2;
        check({"R10 valid ", note}, {63'd0, out_valid}, 64'd1);
        check({tg, " data"}, out_data, use_exp ? exp_d : md);
        check({"R12 wide ", note}, {63'd0, out_wide}, {63'd0, mw});
        check({"R11 err ", note}, {63'd0, out_err}, {63'd0, me});
    endtask

    task automatic idle_check(input string note);
        logic [63:0] held;
        logic hw;
        held = out_data;
        hw = out_wide;
        @(negedge clk);
        in_valid = 1'b0; in_op = 4'd3; rd_data = 64'hA5A5_5A5A_0F0F_F0F0;
        @(posedge clk);
        #2;
        check({"R10 valid low ", note}, {63'd0, out_valid}, 64'd0);
        check({"R10 hold data ", note}, out_data, held);
        check({"R10 hold wide ", note}, {63'd0, out_wide}, {63'd0, hw});
        check({"R11 err clear ", note}, {63'd0, out_err}, 64'd0);
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    localparam logic [63:0] DST = 64'h1111_2222_3333_4444;

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset valid", {63'd0, out_valid}, 64'd0);
        check("R1 reset err",   {63'd0, out_err},   64'd0);
        check("R1 reset wide",  {63'd0, out_wide},  64'd0);
        check("R1 reset data",  out_data,           64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 byte and half extension
        run(4'd0, 1, 64'h1234_5678_9ABC_DE80, DST, 0, 0, 0, 64'hFFFF_FF80, 1, "ldb signed");
        run(4'd0, 0, 64'h1234_5678_9ABC_DE80, DST, 0, 0, 0, 64'h0000_0080, 1, "ldb unsigned");
        run(4'd1, 1, 64'h0000_0000_0000_8001, DST, 0, 0, 0, 64'hFFFF_8001, 1, "ldh signed");
        run(4'd1, 0, 64'h0000_0000_0000_8001, DST, 0, 0, 0, 64'h0000_8001, 1, "ldh unsigned");
        // R3 word and double
        run(4'd2, 1, 64'hDEAD_BEEF_9234_5678, DST, 0, 0, 0, 64'h9234_5678, 1, "ldw");
        run(4'd3, 1, 64'hDEAD_BEEF_1234_5678, DST, 0, 0, 0, 64'hDEAD_BEEF_1234_5678, 1, "ldd");
        // R4 and R5 expansion
        run(4'd4, 1, 64'h0000_0000_0000_817F, DST, 0, 0, 0, 64'hFF81_007F, 1, "exp2 signed");
        run(4'd4, 0, 64'h0000_0000_0000_817F, DST, 0, 0, 0, 64'h0081_007F, 1, "exp2 unsigned");
        run(4'd5, 1, 64'h0000_0000_8001_FF10, DST, 0, 0, 0, 64'hFF80_0001_FFFF_0010, 1, "exp4 signed");
        run(4'd5, 0, 64'h0000_0000_8001_FF10, DST, 0, 0, 0, 64'h0080_0001_00FF_0010, 1, "exp4 unsigned");
        // R6 and R7 align
        run(4'd6, 0, 64'h0000_0000_0000_ABCD, DST, 0, 0, 0, 64'hABCD_1111_2222_3333, 1, "align half");
        run(4'd7, 1, 64'h0000_0000_0000_00EE, DST, 0, 0, 0, 64'hEE11_1122_2233_3344, 1, "align byte");
        // R8 and R9 predication
        run(4'd3, 0, 64'hFFFF_FFFF_FFFF_FFFF, DST, 1, 0, 0, 64'd0, 1, "R9 cond false");
        run(4'd6, 0, 64'hFFFF_FFFF_FFFF_FFFF, DST, 1, 1, 1, 64'd0, 1, "R9 inverted true flag");
        run(4'd2, 0, 64'h0000_0000_CAFE_F00D, DST, 1, 0, 1, 64'hCAFE_F00D, 1, "R9 inverted false flag");
        run(4'd2, 0, 64'h0000_0000_CAFE_F00D, DST, 1, 1, 0, 64'hCAFE_F00D, 1, "R9 cond true");
        run(4'd2, 0, 64'h0000_0000_CAFE_F00D, DST, 0, 0, 1, 64'hCAFE_F00D, 1, "R9 pred disabled");
        // R11 undefined opcode and single-cycle error
        run(4'd9, 0, 64'h1234_5678_9ABC_DEF0, DST, 0, 0, 0, 64'd0, 1, "undefined 9");
        idle_check("after undefined");
        run(4'd15, 1, 64'hFFFF_FFFF_FFFF_FFFF, DST, 1, 1, 0, 64'd0, 1, "undefined 15");
        run(4'd7, 0, 64'h0000_0000_0000_0012, DST, 0, 0, 0, 64'h1211_1122_2233_3344, 1, "R11 err drops");
        idle_check("R10 idle gap");

        // mixed stimulus against the model
        for (int k = 0; k < 400; k++) begin
            logic [63:0] r, d;
            r = {$urandom, $urandom};
            d = {$urandom, $urandom};
            run(4'($urandom_range(0, 15)), 1'($urandom), r, d, 1'($urandom),
                1'($urandom), 1'($urandom), 64'd0, 0, "mixed");
            if (k % 37 == 0) idle_check("mixed idle");
        end

        @(negedge clk);
        in_valid = 1'b0;
        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule